// File: doc/BRIEF.md
# Conversion Start Qualifier

This block sits between the control pins of a successive-approximation converter and its bit sequencer. It watches chip enable (active high), chip select (active low), the read/convert line (low requests a conversion) and the byte-address line, all of which arrive asynchronously. The block brings them onto the system clock and turns them into one single-cycle start pulse for the sequencer. Together with that pulse it provides a latched flag that tells the sequencer whether to stop after eight bits or to run all twelve.

A start is recognised when the three qualifying inputs first become active together. Any one of them may be the last to reach its active level, and two or three of them may change in the same cycle. The sequencer feeds back a busy flag. The block copies this flag to its status output, and while busy is high a new request can neither restart nor extend the running conversion. The address line is sampled only when a start is accepted. Every other input acts only through the combined condition.

Top module: `cnvs_start_ctl`

## Requirements
- R1: `start_o` goes high for exactly one clock cycle. This happens at the third rising clock edge after `ce_i`=1, `cs_n_i`=0 and `rc_n_i`=0 first hold together, because there are two synchroniser stages and one output register.
- R2: Any of `ce_i`, `cs_n_i` or `rc_n_i` can be the input that completes the condition and produces the start. All three changing in the same cycle also produces one start.
- R3: While `ce_i`=0 or `cs_n_i`=1, no start pulse is produced, whatever the other inputs do.
- R4: If the condition rises while `busy_i`=1, no pulse is produced and `short_o` keeps its value.
- R5: On each accepted start, `short_o` takes the synchronised value of `a0_i`. A value of 1 selects an 8-bit conversion and 0 selects a 12-bit conversion. `short_o` is valid in the same cycle in which `start_o` is high.
- R6: Changes on `a0_i` between accepted starts leave `short_o` unchanged.
- R7: `status_o` equals `busy_i` in every cycle.
- R8: A condition that is held active gives one pulse only. After that, the condition must go inactive before another start can occur, and this also holds when busy falls while the condition is still held.
- R9: During reset, and after it, `start_o`=0 and `short_o`=0 until the first accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| ce_i | input | 1 | Chip enable, active high, asynchronous |
| cs_n_i | input | 1 | Chip select, active low, asynchronous |
| rc_n_i | input | 1 | Read/convert select; low requests a conversion |
| a0_i | input | 1 | Byte-address line; 1 selects a short (8-bit) conversion on start |
| busy_i | input | 1 | Sequencer busy flag, on the system clock |
| start_o | output | 1 | One-cycle conversion start pulse |
| short_o | output | 1 | Latched length flag: 1 for 8-bit, 0 for 12-bit |
| status_o | output | 1 | Conversion-in-progress status, follows busy |

## Verification
The start decode is tested with each of the three qualifiers as the last one to change, and with all three changing at once. These patterns show whether the design detects the edge of the combined condition rather than the edge of one fixed input. Patterns in which one qualifier is held in its blocking level show whether that input really gates the start. Rising conditions while busy is high, and conditions held across the fall of busy, separate a design that gates on busy from one that records a request and launches it later. Starts with the address line at each level, followed by toggling it afterwards, show both the capture of the length flag and its isolation from later changes.

// File: rtl/cnvs_pkg.sv
package cnvs_pkg;

  // Width of the control bundle passed through the synchroniser
  localparam int unsigned CTL_W = 4;

  // Bit positions of the control bundle
  localparam int unsigned IDX_CE   = 0;
  localparam int unsigned IDX_CS_N = 1;
  localparam int unsigned IDX_RC_N = 2;
  localparam int unsigned IDX_A0   = 3;

  // Idle value of the bundle: nothing selected, no conversion requested
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b0110;

  typedef enum logic {
    LEN_FULL  = 1'b0,
    LEN_SHORT = 1'b1
  } conv_len_e;

endpackage

// File: rtl/cnvs_sync.sv
module cnvs_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stg_d;
      if (g == 0) begin : g_first
        assign stg_d = d_i;
      end else begin : g_next
        assign stg_d = stg_q[g-1];
      end

      always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
          stg_q[g] <= RST_VAL;
        end else begin
          stg_q[g] <= stg_d;
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cnvs_trigger.sv
module cnvs_trigger (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic ce_i,
  input  logic cs_n_i,
  input  logic rc_n_i,
  input  logic busy_i,
  output logic accept_o,
  output logic start_o
);

  logic cond_now;
  logic cond_q, cond_d;
  logic start_q, start_d;
  logic cond_rise;

  // Next-state logic
  always_comb begin
    cond_now  = ce_i & ~cs_n_i & ~rc_n_i;
    cond_rise = cond_now & ~cond_q;
    accept_o  = cond_rise & ~busy_i;
    cond_d    = cond_now;
    start_d   = accept_o;
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cond_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      cond_q  <= cond_d;
      start_q <= start_d;
    end
  end

  assign start_o = start_q;

  // R1
  start_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    start_q |=> !start_q);

  // R4
  no_start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    busy_i |=> !start_q);

endmodule

// File: rtl/cnvs_len_latch.sv
module cnvs_len_latch
  import cnvs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic load_i,
  input  logic a0_i,
  output logic short_o
);

  conv_len_e len_q, len_d;
  logic      len_en;

  // Next-state logic
  always_comb begin
    len_en = load_i;
    len_d  = a0_i ? LEN_SHORT : LEN_FULL;
  end

  // Register with written-out enable
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      len_q <= LEN_FULL;
    end else if (len_en) begin
      len_q <= len_d;
    end
  end

  assign short_o = (len_q == LEN_SHORT);

  // R6
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !load_i |=> $stable(short_o));

endmodule

// File: rtl/cnvs_start_ctl.sv
module cnvs_start_ctl
  import cnvs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic ce_i,
  input  logic cs_n_i,
  input  logic rc_n_i,
  input  logic a0_i,
  input  logic busy_i,
  output logic start_o,
  output logic short_o,
  output logic status_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [CTL_W-1:0] ctl_raw;
  logic [CTL_W-1:0] ctl_s;
  logic             accept;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  always_comb begin
    ctl_raw           = CTL_IDLE;
    ctl_raw[IDX_CE]   = ce_i;
    ctl_raw[IDX_CS_N] = cs_n_i;
    ctl_raw[IDX_RC_N] = rc_n_i;
    ctl_raw[IDX_A0]   = a0_i;
  end

  cnvs_sync #(
    .W      (CTL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTL_IDLE)
  ) sync_i (
    .clk_i  (clk_i),
    .rst_n_i(rst_n),
    .d_i    (ctl_raw),
    .q_o    (ctl_s)
  );

  cnvs_trigger trig_i (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .ce_i    (ctl_s[IDX_CE]),
    .cs_n_i  (ctl_s[IDX_CS_N]),
    .rc_n_i  (ctl_s[IDX_RC_N]),
    .busy_i  (busy_i),
    .accept_o(accept),
    .start_o (start_o)
  );

  cnvs_len_latch len_i (
    .clk_i  (clk_i),
    .rst_n_i(rst_n),
    .load_i (accept),
    .a0_i   (ctl_s[IDX_A0]),
    .short_o(short_o)
  );

  assign status_o = busy_i;

  // R3
  start_needs_select_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_o |-> $past(ctl_s[IDX_CE] & ~ctl_s[IDX_CS_N] & ~ctl_s[IDX_RC_N]));

  // R5
  len_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_o |-> (short_o == $past(ctl_s[IDX_A0])));

endmodule

// File: tb/cnvs_start_ctl_tb_top.sv
module cnvs_start_ctl_tb_top;

  logic clk = 1'b0;
  logic rst_n;
  logic ce, cs_n, rc_n, a0, busy;
  logic start_w, short_w, status_w;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int win_cnt;
  int win_first;
  logic win_short;

  always #10 clk = ~clk;

  cnvs_start_ctl dut_i (
    .clk_i   (clk),
    .rst_n_i (rst_n),
    .ce_i    (ce),
    .cs_n_i  (cs_n),
    .rc_n_i  (rc_n),
    .a0_i    (a0),
    .busy_i  (busy),
    .start_o (start_w),
    .short_o (short_w),
    .status_o(status_w)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Watch N cycles, count pulses, note first pulse cycle and flag then
  task automatic watch(input int n);
    win_cnt   = 0;
    win_first = 0;
    win_short = short_w;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (start_w) begin
        win_cnt++;
        if (win_first == 0) begin
          win_first = i;
          win_short = short_w;
        end
      end
    end
  endtask

  task automatic go_idle();
    ce = 1'b0; cs_n = 1'b1; rc_n = 1'b1;
    watch(6);
  endtask

  task automatic t_reset();
    check("R9 start after reset", start_w, 0);
    check("R9 short after reset", short_w, 0);
    check("R7 status idle", status_w, busy);
  endtask

  // which: 0 = ce last, 1 = cs_n last, 2 = rc_n last, 3 = all together
  task automatic t_last_input(input int which);
    go_idle();
    ce   = (which == 0 || which == 3) ? 1'b0 : 1'b1;
    cs_n = (which == 1 || which == 3) ? 1'b1 : 1'b0;
    rc_n = (which == 2 || which == 3) ? 1'b1 : 1'b0;
    watch(6);
    check("R2 partial condition no start", win_cnt, 0);
    ce = 1'b1; cs_n = 1'b0; rc_n = 1'b0;
    watch(8);
    check("R2 one start for last input", win_cnt, 1);
    check("R1 start latency", win_first, 3);
    go_idle();
  endtask

  task automatic t_blocked();
    go_idle();
    ce = 1'b0; cs_n = 1'b0;
    rc_n = 1'b0; watch(3); rc_n = 1'b1; watch(3); rc_n = 1'b0; watch(6);
    check("R3 ce low blocks", win_cnt, 0);
    go_idle();
    ce = 1'b1; cs_n = 1'b1;
    rc_n = 1'b0; watch(3); rc_n = 1'b1; watch(3); rc_n = 1'b0; watch(6);
    check("R3 cs_n high blocks", win_cnt, 0);
    go_idle();
  endtask

  task automatic t_length();
    go_idle();
    a0 = 1'b1; ce = 1'b1; cs_n = 1'b0; rc_n = 1'b0;
    watch(8);
    check("R5 start with a0 high", win_cnt, 1);
    check("R5 short flag on pulse", win_short, 1);
    a0 = 1'b0; watch(6);
    check("R6 a0 change after start ignored", short_w, 1);
    go_idle();
    a0 = 1'b0; ce = 1'b1; cs_n = 1'b0; rc_n = 1'b0;
    watch(8);
    check("R5 start with a0 low", win_cnt, 1);
    check("R5 full flag on pulse", win_short, 0);
    a0 = 1'b1; watch(6);
    check("R6 a0 toggle keeps full", short_w, 0);
    go_idle();
    a0 = 1'b0; watch(6);
    check("R6 idle a0 change", short_w, 0);
  endtask

  task automatic t_busy();
    go_idle();
    busy = 1'b1;
    @(negedge clk);
    check("R7 status follows busy high", status_w, 1);
    a0 = 1'b1; ce = 1'b1; cs_n = 1'b0; rc_n = 1'b0;
    watch(8);
    check("R4 no start while busy", win_cnt, 0);
    check("R4 short unchanged while busy", short_w, 0);
    busy = 1'b0;
    @(negedge clk);
    check("R7 status follows busy low", status_w, 0);
    watch(8);
    check("R8 no late start after busy falls", win_cnt, 0);
    go_idle();
    ce = 1'b1; cs_n = 1'b0; rc_n = 1'b0;
    watch(8);
    check("R8 start after release", win_cnt, 1);
    check("R5 short captured after busy", win_short, 1);
    go_idle();
  endtask

  task automatic t_held();
    go_idle();
    a0 = 1'b0; ce = 1'b1; cs_n = 1'b0; rc_n = 1'b0;
    watch(40);
    check("R8 held condition one pulse", win_cnt, 1);
    check("R1 single-cycle pulse latency", win_first, 3);
    go_idle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ce = 1'b0; cs_n = 1'b1; rc_n = 1'b1; a0 = 1'b0; busy = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset();
    t_last_input(0);
    t_last_input(1);
    t_last_input(2);
    t_last_input(3);
    t_blocked();
    t_length();
    t_busy();
    t_held();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule